// File: doc/BRIEF.md
# Receive-Only I2C Target Front End

This block is the bus-facing receiver of a display controller. It watches the two I2C lines, removes short glitches with a digital filter running on the system clock, and finds START and STOP conditions. After a START it collects the address byte. If the byte names this device and asks for a write, the block acknowledges it. It then acknowledges every following byte and hands each one downstream. The block never sends data. The only thing it does to the bus is pull SDA low during acknowledge slots.

The 7-bit target address has six fixed upper bits, `011100`. Its last bit comes from the `addr_sel_i` strap, so two of these receivers can share one bus. A 3-bit board-level subaddress is registered and passed on to downstream logic. That logic uses it together with received command bytes to pick between several devices that answer to the same bus address.

Received bytes leave on a valid-only stream: `rx_valid` is a one-cycle strobe carrying `rx_data` and `rx_first`. There is no ready input. The bus cannot be stalled, because clock stretching is not provided. The consumer must therefore accept each strobe in the cycle it appears. Successive strobes are at least one full SCL byte period apart. `xfer_end` marks the STOP that closes an addressed transfer.

Top module: `lcd_i2c_rx`

## Requirements
- R1: While `rst_n` is low, `sda_oe`, `rx_valid` and `xfer_end` are all 0.
- R2: An address byte equal to `{011100, addr_sel_i, 0}`, received MSB first, is acknowledged: `sda_oe` is 1 throughout the high phase of the ninth SCL pulse.
- R3: An address byte whose upper six bits differ from `011100`, or whose bit 1 differs from `addr_sel_i`, is not acknowledged. Later bytes before the next START are neither acknowledged nor emitted.
- R4: A matching address with bit 0 = 1 (read) is not acknowledged. The rest of that transfer is ignored in the same way as in R3.
- R5: Each data byte after an acknowledged address is acknowledged and emitted MSB first as a single-cycle `rx_valid` pulse with `rx_data` equal to the byte.
- R6: `rx_first` is 1 with the first data byte after each acknowledged address, and 0 with every later byte.
- R7: A STOP that ends an addressed transfer gives exactly one single-cycle `xfer_end` pulse. A STOP in any other state gives none.
- R8: A repeated START at any point drops the partly received byte without emitting it, and restarts address reception.
- R9: `sda_oe` is asserted only between the falling edge of the eighth SCL pulse and the falling edge of the ninth. It is 0 during every data-bit high phase.
- R10: A pulse on SDA or SCL shorter than `FILT_LEN` system clocks has no effect. A one-cycle SDA pulse while SCL is high creates neither a STOP nor a START.
- R11: `subaddr_o` follows `subaddr_i` through one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| addr_sel_i | input | 1 | Strap giving address bit 1 |
| subaddr_i | input | 3 | Board-level device subaddress |
| subaddr_o | output | 3 | Registered subaddress for downstream selection |
| rx_valid | output | 1 | One-cycle strobe for a received data byte |
| rx_data | output | 8 | Received data byte |
| rx_first | output | 1 | Byte is the first one after the address |
| xfer_end | output | 1 | One-cycle pulse on STOP of an addressed transfer |

## Verification
The address decoder is driven with a matching write, a mismatch in the strap bit alone, a mismatch in the fixed upper bits, and a matching read. These separate the full compare from a partial one and show that the direction bit is honoured. Data runs use values of all ones, all zeros and mixed patterns, which expose bit-order and shift errors. A repeated START is driven after three bits of a byte and also from the ignore state, to show that partial bytes are dropped and address reception restarts. One-cycle SDA spikes in both directions while SCL is high check that the filter prevents false STOP and START detection.

// File: rtl/lcd_i2c_rx_pkg.sv
package lcd_i2c_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_ADDR,
    RX_DATA,
    RX_SKIP
  } rx_state_e;
endpackage

// File: rtl/lcd_i2c_rx_deglitch.sv
module lcd_i2c_rx_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;
  logic                   clean_q;

  // Idle bus level is high, so everything resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      win_q   <= '1;
      clean_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&win_q)       clean_q <= 1'b1;
      else if (~|win_q) clean_q <= 1'b0;
    end
  end

  assign clean_o = clean_q;

  AST_FILT_CONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clean_q) |-> ($past(sync_q[SYNC_STAGES-1], 2) == clean_q)); // R10
endmodule

// File: rtl/lcd_i2c_rx_cond.sv
module lcd_i2c_rx_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise_o = scl_i & ~scl_q;
    scl_fall_o = ~scl_i & scl_q;
    start_o    = scl_i & scl_q & sda_q & ~sda_i;
    stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/lcd_i2c_rx_fsm.sv
module lcd_i2c_rx_fsm
  import lcd_i2c_rx_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b011100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_sel_i,
  output logic              sda_oe_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_first_o,
  output logic              xfer_end_o
);
  rx_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              ack_q, oe_q, valid_q, first_q, first_pend_q, end_q;
  logic [BYTE_W-1:0] data_q;
  logic              addr_hit;
  logic              in_byte;

  assign addr_hit = (sh_q == {ADDR_HI, addr_sel_i, 1'b0});
  assign in_byte  = (st_q == RX_ADDR) || (st_q == RX_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= RX_IDLE;
      cnt_q        <= '0;
      sh_q         <= '0;
      ack_q        <= 1'b0;
      oe_q         <= 1'b0;
      valid_q      <= 1'b0;
      data_q       <= '0;
      first_q      <= 1'b0;
      first_pend_q <= 1'b0;
      end_q        <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      first_q <= 1'b0;
      end_q   <= 1'b0;
      if (start_i) begin
        // A START, repeated or not, always restarts address reception.
        st_q  <= RX_ADDR;
        cnt_q <= '0;
        ack_q <= 1'b0;
        oe_q  <= 1'b0;
      end else if (stop_i) begin
        end_q <= (st_q == RX_DATA);
        st_q  <= RX_IDLE;
        cnt_q <= '0;
        ack_q <= 1'b0;
        oe_q  <= 1'b0;
      end else if (in_byte) begin
        if (ack_q) begin
          // The acknowledge slot ends on the ninth falling edge.
          if (scl_fall_i) begin
            ack_q <= 1'b0;
            oe_q  <= 1'b0;
            cnt_q <= '0;
          end
        end else if (cnt_q != CNT_W'(BYTE_W)) begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end else if (scl_fall_i) begin
          if (st_q == RX_ADDR) begin
            if (addr_hit) begin
              st_q         <= RX_DATA;
              ack_q        <= 1'b1;
              oe_q         <= 1'b1;
              first_pend_q <= 1'b1;
            end else begin
              st_q <= RX_SKIP;
            end
          end else begin
            ack_q        <= 1'b1;
            oe_q         <= 1'b1;
            valid_q      <= 1'b1;
            data_q       <= sh_q;
            first_q      <= first_pend_q;
            first_pend_q <= 1'b0;
          end
        end
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign rx_valid_o = valid_q;
  assign rx_data_o  = data_q;
  assign rx_first_o = first_q;
  assign xfer_end_o = end_q;

  AST_OE_RISE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(scl_fall_i)); // R9
  AST_OE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> $past(scl_fall_i || start_i || stop_i)); // R9
  AST_NO_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_q) && ($past(st_q) == RX_ADDR)) |-> !$past(sh_q[0])); // R4
  AST_VALID_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(scl_fall_i)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R5
  AST_END_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> $past(stop_i)); // R7
  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |=> !end_q); // R7
endmodule

// File: rtl/lcd_i2c_rx.sv
module lcd_i2c_rx
  import lcd_i2c_rx_pkg::*;
#(
  parameter logic [5:0] ADDR_HI     = 6'b011100,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter int         SUBADDR_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic                 addr_sel_i,
  input  logic [SUBADDR_W-1:0] subaddr_i,
  output logic [SUBADDR_W-1:0] subaddr_o,
  output logic                 rx_valid,
  output logic [BYTE_W-1:0]    rx_data,
  output logic                 rx_first,
  output logic                 xfer_end
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] line_raw, line_clean;
  logic scl_rise, scl_fall, cond_start, cond_stop;
  logic [SUBADDR_W-1:0] subaddr_q;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    lcd_i2c_rx_deglitch #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (line_raw[g]),
      .clean_o(line_clean[g])
    );
  end

  lcd_i2c_rx_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (line_clean[0]),
    .sda_i     (line_clean[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (cond_start),
    .stop_o    (cond_stop)
  );

  lcd_i2c_rx_fsm #(
    .ADDR_HI(ADDR_HI)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_i     (line_clean[1]),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (cond_start),
    .stop_i    (cond_stop),
    .addr_sel_i(addr_sel_i),
    .sda_oe_o  (sda_oe),
    .rx_valid_o(rx_valid),
    .rx_data_o (rx_data),
    .rx_first_o(rx_first),
    .xfer_end_o(xfer_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) subaddr_q <= '0;
    else        subaddr_q <= subaddr_i;
  end
  assign subaddr_o = subaddr_q;

  AST_NO_OE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cond_stop |=> !sda_oe); // R9
  AST_START_CLEARS_END: assert property (@(posedge clk) disable iff (!rst_n)
    cond_start |=> !xfer_end); // R8
endmodule

// File: tb/tb_lcd_i2c_rx.sv
module tb_lcd_i2c_rx;
  localparam int Q = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, g_sda = 1'b0;
  logic addr_sel = 1'b1;
  logic [2:0] sub_in = 3'b101;
  logic [2:0] sub_out;
  logic sda_oe, rx_valid, rx_first, xfer_end;
  logic [7:0] rx_data;
  logic scl_line, sda_line;

  always #4 clk = ~clk;

  assign scl_line = m_scl;
  assign sda_line = (m_sda ^ g_sda) & ~sda_oe;

  lcd_i2c_rx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_sel_i(addr_sel), .subaddr_i(sub_in),
    .subaddr_o(sub_out), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_first(rx_first), .xfer_end(xfer_end)
  );

  int checks = 0, errors = 0;
  int mstate = 0;            // 0 idle, 1 address, 2 data, 3 ignore
  bit m_first = 0;
  logic [8:0] exp_q[$];
  int exp_end = 0, got_end = 0;
  bit oe_allowed = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Output stream and per-cycle R9 monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe && !oe_allowed) begin
        errors++;
        $display("FAIL R9: actual sda_oe 1 expected 0 outside ack slot");
      end
      if (xfer_end) got_end++;
      if (rx_valid) begin
        if (exp_q.size() == 0) begin
          chk("R8 unexpected byte", 1, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk("R5 rx_data", rx_data, e[7:0]);
          chk("R6 rx_first", rx_first, e[8]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bus_start();
    m_sda = 1; tick(Q);
    m_scl = 1; tick(Q);
    m_sda = 0; tick(Q);
    m_scl = 0; tick(Q);
    mstate = 1;
  endtask

  task automatic bus_stop();
    m_sda = 0; tick(Q);
    m_scl = 1; tick(Q);
    m_sda = 1; tick(Q);
    if (mstate == 2) exp_end++;
    mstate = 0;
    tick(Q);
    chk("R7 xfer_end count", got_end, exp_end);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input int gl);
    for (int i = 0; i < n; i++) begin
      m_sda = b[7-i]; tick(Q);
      m_scl = 1; tick(8);
      if (i == gl) begin g_sda = 1; tick(1); g_sda = 0; tick(7); end
      else tick(8);
      chk("R9 oe during data bit", sda_oe, 0);
      tick(Q/2);
      m_scl = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gl, input string tag);
    bit ack_exp;
    ack_exp = 0;
    if (mstate == 1) begin
      ack_exp = (b[7:1] == {6'b011100, addr_sel}) && !b[0];
      mstate = ack_exp ? 2 : 3;
      m_first = 1;
    end else if (mstate == 2) begin
      ack_exp = 1;
      exp_q.push_back({m_first, b});
      m_first = 0;
    end
    send_bits(b, 8, gl);
    m_sda = 1; oe_allowed = 1; tick(Q);
    m_scl = 1; tick(Q/2);
    chk(tag, sda_oe, ack_exp);
    tick(Q/2);
    m_scl = 0; tick(Q);
    oe_allowed = 0;
  endtask

  initial begin
    tick(10);
    chk("R1 sda_oe in reset", sda_oe, 0);
    chk("R1 rx_valid in reset", rx_valid, 0);
    chk("R1 xfer_end in reset", xfer_end, 0);
    rst_n = 1; tick(20);
    chk("R11 subaddr", sub_out, 3'b101);
    sub_in = 3'b010; tick(2);
    chk("R11 subaddr follow", sub_out, 3'b010);

    // R2 R5 R6 R7: addressed write with several data patterns
    bus_start();
    send_byte(8'h72, -1, "R2 address ack");
    send_byte(8'hA5, -1, "R5 data ack");
    send_byte(8'h3C, -1, "R5 data ack");
    send_byte(8'hFF, -1, "R5 data ack");
    send_byte(8'h00, -1, "R5 data ack");
    bus_stop();

    // R3: strap bit mismatch, then upper-bit mismatch
    bus_start();
    send_byte(8'h70, -1, "R3 strap mismatch nack");
    send_byte(8'h55, -1, "R3 ignored byte nack");
    bus_stop();
    bus_start();
    send_byte(8'h62, -1, "R3 upper mismatch nack");
    bus_stop();

    // R4: read request
    bus_start();
    send_byte(8'h73, -1, "R4 read nack");
    send_byte(8'h11, -1, "R4 ignored byte nack");
    bus_stop();

    // R2 with the other strap level
    addr_sel = 0;
    bus_start();
    send_byte(8'h70, -1, "R2 address ack strap 0");
    send_byte(8'h81, -1, "R5 data ack");
    bus_stop();
    addr_sel = 1;

    // R8: repeated START inside a data byte, then from the ignore state
    bus_start();
    send_byte(8'h72, -1, "R2 address ack");
    send_bits(8'hC0, 3, -1);
    bus_start();
    send_byte(8'h72, -1, "R8 address ack after Sr");
    send_byte(8'h9E, -1, "R8 data ack after Sr");
    bus_stop();
    bus_start();
    send_byte(8'h62, -1, "R3 upper mismatch nack");
    bus_start();
    send_byte(8'h72, -1, "R8 address ack from ignore");
    send_byte(8'h44, -1, "R8 data ack from ignore");
    bus_stop();

    // R10: one-cycle SDA spikes while SCL is high
    bus_start();
    send_byte(8'h72, -1, "R2 address ack");
    send_byte(8'h0F, 2, "R10 ack despite rising spike");
    send_byte(8'h0F, 5, "R10 ack despite falling spike");
    bus_stop();

    tick(Q);
    chk("R5 all expected bytes seen", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule